// File: doc/BRIEF.md
# Phased Coefficient Loader for an Anti-Alias Filter

This block is the register side of a polyphase anti-alias filter's coefficient store. A host writes coefficient words one at a time into a bank of staging registers. Those writes leave the coefficient memory untouched. A separate write to a trigger address then copies every staged word, in a single cycle, into the phase slot named by an internal phase pointer. The pointer then moves to the next slot. Sixteen stage-then-trigger rounds program a complete filter.

The `NUM_STAGE` parameter sets the number of staging words: five for a horizontal filter and two for a vertical one. Luma and chroma each use their own instance. The filter datapath reads one whole phase row through a registered read port. A control bit tells the datapath to bypass the filter. A sticky flag reports when all phases have been written since the last pointer clear.

Top module: `coef_loader`

## Requirements
- R1: After reset, the phase pointer is 0, `all_loaded` is 0, `bypass` is 0, and every coefficient word reads as 0.
- R2: A write to a staging address (0 to `NUM_STAGE`-1) changes no coefficient word, as seen at the read port.
- R3: A write to the trigger address (`NUM_STAGE`) copies all staged words into the row at the current pointer in one cycle. The data value of that write is ignored. Staged word k appears at `rd_data[k*WORD_W +: WORD_W]`.
- R4: Each trigger advances the pointer by one, and the pointer wraps from `NUM_PHASE`-1 to 0.
- R5: A write to the pointer-clear address (`NUM_STAGE`+1) sets the pointer to 0 and clears `all_loaded`. It does not change stored coefficients.
- R6: `all_loaded` rises after the `NUM_PHASE`th trigger since the last clear or reset. It stays high through later triggers until the next clear.
- R7: `rd_data` shows the row chosen by `rd_phase` one clock later. The row comes from the memory contents before that same edge.
- R8: Staged words keep their values across triggers, so a trigger with no new staging writes commits the same words again.
- R9: A write to the control address (`NUM_STAGE`+2) loads `bypass` from data bit 0. No other write changes `bypass`.
- R10: Writes to addresses above `NUM_STAGE`+2 have no effect on the pointer, `all_loaded`, `bypass` or the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host word address |
| wr_data | input | WORD_W | Host write data |
| rd_phase | input | PTR_W | Phase row requested by the datapath |
| rd_data | output | NUM_STAGE*WORD_W | Registered coefficient row |
| phase_ptr | output | PTR_W | Phase slot the next trigger fills |
| all_loaded | output | 1 | Sticky: every phase written since the last clear |
| bypass | output | 1 | Filter bypass control |

## Verification
The bench checks that a staging write leaves the read port alone. A design that wrote through early would show half-built rows. It also checks that a trigger with no new staging writes repeats the earlier words; a design that cleared staging on commit would store zeros. The bench follows the pointer through its wrap at 15 and through clears made partway into a sequence. A wrong wrap or a missed clear would put rows in the wrong slots or raise `all_loaded` at the wrong time. Finally, the bench checks the one-cycle read latency, so a combinational read or an extra pipeline stage shows up as a mismatch.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;
    // Kind of host access decoded from the write address
    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_STAGE = 3'd1,
        ACC_TRIG  = 3'd2,
        ACC_CLR   = 3'd3,
        ACC_CTL   = 3'd4
    } acc_kind_e;
endpackage

// File: rtl/coef_stage_bank.sv
module coef_stage_bank #(
    parameter int NUM_STAGE = 5,
    parameter int WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NUM_STAGE-1:0]        wr_sel,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [NUM_STAGE*WORD_W-1:0] stage_flat
);
    typedef struct packed {
        logic [NUM_STAGE-1:0][WORD_W-1:0] word;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_STAGE; k++) begin
            if (wr_en && wr_sel[k]) st_d.word[k] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NUM_STAGE; g++) begin : g_flat
            assign stage_flat[g*WORD_W +: WORD_W] = st_q.word[g];
        end
    endgenerate
endmodule

// File: rtl/coef_phase_ctr.sv
module coef_phase_ctr #(
    parameter int NUM_PHASE = 16,
    parameter int PTR_W     = $clog2(NUM_PHASE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr,
    output logic             all_loaded
);
    localparam int CNT_W = $clog2(NUM_PHASE + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_PHASE - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_PHASE);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
        logic             full;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else if (adv) begin
            c_d.ptr = (c_q.ptr == LAST_PTR) ? '0 : c_q.ptr + 1'b1;
            if (c_q.cnt != FULL_CNT) c_d.cnt = c_q.cnt + 1'b1;
            if (c_q.cnt == FULL_CNT - 1'b1) c_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ptr        = c_q.ptr;
    assign all_loaded = c_q.full;
endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int NUM_PHASE = 16,
    parameter int ROW_W     = 160,
    parameter int PTR_W     = $clog2(NUM_PHASE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] wr_phase,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [PTR_W-1:0] rd_phase,
    output logic [ROW_W-1:0] rd_row
);
    typedef struct packed {
        logic [NUM_PHASE-1:0][ROW_W-1:0] mem;
        logic [ROW_W-1:0]                rd;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NUM_PHASE; p++) begin
            if (we && (wr_phase == PTR_W'(p))) s_d.mem[p] = wr_row;
        end
        s_d.rd = '0;
        for (int p = 0; p < NUM_PHASE; p++) begin
            if (rd_phase == PTR_W'(p)) s_d.rd = s_q.mem[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_row = s_q.rd;
endmodule

// File: rtl/coef_loader.sv
module coef_loader
    import coef_ld_pkg::*;
#(
    parameter int NUM_STAGE = 5,
    parameter int WORD_W    = 32,
    parameter int NUM_PHASE = 16,
    parameter int ADDR_W    = 4,
    parameter int PTR_W     = $clog2(NUM_PHASE)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [PTR_W-1:0]            rd_phase,
    output logic [NUM_STAGE*WORD_W-1:0] rd_data,
    output logic [PTR_W-1:0]            phase_ptr,
    output logic                        all_loaded,
    output logic                        bypass
);
    localparam int ROW_W = NUM_STAGE * WORD_W;
    localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(NUM_STAGE);
    localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(NUM_STAGE + 1);
    localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(NUM_STAGE + 2);

    acc_kind_e            kind;
    logic [NUM_STAGE-1:0] stage_sel;
    logic [ROW_W-1:0]     stage_flat;

    // Address decode
    always_comb begin
        kind      = ACC_NONE;
        stage_sel = '0;
        if (wr_en) begin
            if (wr_addr == TRIG_ADDR)      kind = ACC_TRIG;
            else if (wr_addr == CLR_ADDR)  kind = ACC_CLR;
            else if (wr_addr == CTL_ADDR)  kind = ACC_CTL;
            else if (wr_addr < TRIG_ADDR)  kind = ACC_STAGE;
        end
        for (int k = 0; k < NUM_STAGE; k++) begin
            stage_sel[k] = (kind == ACC_STAGE) && (wr_addr == ADDR_W'(k));
        end
    end

    // Control register, two-process
    typedef struct packed {
        logic bypass;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (kind == ACC_CTL) ctl_d.bypass = wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign bypass = ctl_q.bypass;

    coef_stage_bank #(
        .NUM_STAGE (NUM_STAGE),
        .WORD_W    (WORD_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (kind == ACC_STAGE),
        .wr_sel     (stage_sel),
        .wr_data    (wr_data),
        .stage_flat (stage_flat)
    );

    coef_phase_ctr #(
        .NUM_PHASE (NUM_PHASE),
        .PTR_W     (PTR_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (kind == ACC_TRIG),
        .clr        (kind == ACC_CLR),
        .ptr        (phase_ptr),
        .all_loaded (all_loaded)
    );

    coef_store #(
        .NUM_PHASE (NUM_PHASE),
        .ROW_W     (ROW_W),
        .PTR_W     (PTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (kind == ACC_TRIG),
        .wr_phase (phase_ptr),
        .wr_row   (stage_flat),
        .rd_phase (rd_phase),
        .rd_row   (rd_data)
    );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int NUM_STAGE = 5,
    parameter int WORD_W    = 32,
    parameter int NUM_PHASE = 16,
    parameter int ADDR_W    = 4,
    parameter int PTR_W     = $clog2(NUM_PHASE)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [PTR_W-1:0]            rd_phase,
    input logic [NUM_STAGE*WORD_W-1:0] rd_data,
    input logic [PTR_W-1:0]            phase_ptr,
    input logic                        all_loaded,
    input logic                        bypass
);
    logic trig_w, clr_w, ctl_w, trig_prev;
    assign trig_w = wr_en && (wr_addr == ADDR_W'(NUM_STAGE));
    assign clr_w  = wr_en && (wr_addr == ADDR_W'(NUM_STAGE + 1));
    assign ctl_w  = wr_en && (wr_addr == ADDR_W'(NUM_STAGE + 2));

    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= 1'b1;
        else        trig_prev <= trig_w;
    end

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_w |=> phase_ptr == (($past(phase_ptr) == PTR_W'(NUM_PHASE - 1)) ? '0 : $past(phase_ptr) + 1'b1));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_w && !clr_w) |=> $stable(phase_ptr));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (phase_ptr == '0) && !all_loaded);

    // R6
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_loaded && !clr_w) |=> all_loaded);

    // R2
    row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_prev && $stable(rd_phase)) |=> $stable(rd_data));

    // R9
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_w |=> $stable(bypass));
endmodule

bind coef_loader coef_loader_chk #(
    .NUM_STAGE (NUM_STAGE),
    .WORD_W    (WORD_W),
    .NUM_PHASE (NUM_PHASE),
    .ADDR_W    (ADDR_W),
    .PTR_W     (PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_phase   (rd_phase),
    .rd_data    (rd_data),
    .phase_ptr  (phase_ptr),
    .all_loaded (all_loaded),
    .bypass     (bypass)
);

// File: tb/coef_loader_tb.sv
module coef_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam int W  = 32;
    localparam int NP = 16;
    localparam int AW = 4;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [W-1:0]      wr_data = '0;
    logic [PW-1:0]     rd_phase = '0;
    logic [NS*W-1:0]   rd_data;
    logic [PW-1:0]     phase_ptr;
    logic              all_loaded;
    logic              bypass;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model
    logic [W-1:0] m_mem [NP][NS];
    logic [W-1:0] m_stage [NS];
    int           m_ptr;
    int           m_cnt;
    bit           m_full;
    bit           m_byp;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_phase(rd_phase), .rd_data(rd_data),
        .phase_ptr(phase_ptr), .all_loaded(all_loaded), .bypass(bypass)
    );

    function automatic logic [NS*W-1:0] exp_row(int p);
        logic [NS*W-1:0] r;
        for (int k = 0; k < NS; k++) r[k*W +: W] = m_mem[p][k];
        return r;
    endfunction

    task automatic check(string req, logic [NS*W-1:0] act, logic [NS*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_wr(int a, logic [W-1:0] d);
        if (a < NS) m_stage[a] = d;
        else if (a == NS) begin
            for (int k = 0; k < NS; k++) m_mem[m_ptr][k] = m_stage[k];
            m_ptr = (m_ptr + 1) % NP;
            m_cnt++;
            if (m_cnt >= NP) m_full = 1'b1;
        end else if (a == NS + 1) begin
            m_ptr = 0; m_cnt = 0; m_full = 1'b0;
        end else if (a == NS + 2) m_byp = d[0];
    endtask

    task automatic check_state(string req);
        check(req, {{(NS*W-PW){1'b0}}, phase_ptr}, (NS*W)'(m_ptr));
        check(req, {{(NS*W-1){1'b0}}, all_loaded}, (NS*W)'(m_full));
        check(req, {{(NS*W-1){1'b0}}, bypass}, (NS*W)'(m_byp));
    endtask

    task automatic do_wr(int a, logic [W-1:0] d, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
        check_state(req);
    endtask

    task automatic do_rd(int p, string req);
        rd_phase = PW'(p);
        @(negedge clk);
        check(req, rd_data, exp_row(p));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) for (int k = 0; k < NS; k++) m_mem[p][k] = '0;
        for (int k = 0; k < NS; k++) m_stage[k] = '0;
        m_ptr = 0; m_cnt = 0; m_full = 1'b0; m_byp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        for (int p = 0; p < NP; p++) do_rd(p, "R1");

        // R2 staging writes leave memory alone
        for (int k = 0; k < NS; k++) do_wr(k, 32'hA000_0000 + k, "R2");
        for (int p = 0; p < 3; p++) do_rd(p, "R2");

        // R3 commit then R8 recommit without restaging
        do_wr(NS, 32'hFFFF_FFFF, "R3");
        do_rd(0, "R3");
        do_wr(NS, 32'h0, "R8");
        do_rd(1, "R8");

        // R4 fill and wrap, R6 full after 16
        for (int i = 2; i < NP; i++) begin
            do_wr(i % NS, 32'hB000_0000 + i, "R4");
            do_wr(NS, 32'h0, "R6");
        end
        do_wr(NS, 32'h0, "R4");
        do_wr(NS, 32'h0, "R6");
        for (int p = 0; p < NP; p++) do_rd(p, "R3");

        // R7 latency: row visible one edge after phase change
        do_wr(0, 32'h1234_5678, "R7");
        do_wr(NS, 32'h0, "R7");
        rd_phase = 4'd0; @(negedge clk); @(negedge clk);
        rd_phase = 4'd5;
        #1 check("R7", rd_data, exp_row(0));
        @(negedge clk);
        check("R7", rd_data, exp_row(5));

        // R5 clear mid-sequence, memory kept
        do_wr(NS + 1, 32'h0, "R5");
        do_rd(2, "R5");
        do_wr(NS, 32'h0, "R5");

        // R9 bypass, R10 unmapped
        do_wr(NS + 2, 32'h1, "R9");
        do_wr(NS + 2, 32'hFFFF_FFFE, "R9");
        do_wr(NS + 2, 32'h3, "R9");
        for (int a = NS + 3; a < 16; a++) do_wr(a, 32'hFFFF_FFFF, "R10");
        do_rd(1, "R10");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            int a;
            r = int'($urandom_range(0, 99));
            if (r < 55)      a = int'($urandom_range(0, NS - 1));
            else if (r < 85) a = NS;
            else if (r < 89) a = NS + 1;
            else if (r < 93) a = NS + 2;
            else             a = int'($urandom_range(NS + 3, 15));
            do_wr(a, $urandom, "R3");
            do_rd(int'($urandom_range(0, NP - 1)), "R3");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule